// File: doc/BRIEF.md
# Parallel-Port Receive Buffer Flush Controller

This block keeps account of a 64-byte receive buffer that sits between a parallel peripheral and memory. Each byte captured from the peripheral bumps an occupancy count. The controller decides when the buffered bytes must be written out to memory and when they must be thrown away instead. It then raises a flush request that carries a byte count and holds it until the memory side acknowledges.

A flush can start for several reasons. The occupancy can reach a selectable burst size. An interrupt can be pending. Software can write one of the port registers, or it can command a reset or an invalidate. The address register can reload. While a memory error is pending, no flush may begin. If a reset, an invalidate or an address reload arrives during that time, the buffered bytes are discarded and a one-cycle invalidate pulse is issued. Register accesses from software never pass through the buffer, so they do not change the count.

Top module: `pp_rx_drain_ctrl`

## Requirements
- R1: After reset, `drain_req_o`, `inval_o` and `level_o` are all 0.
- R2: Each cycle with `byte_wr_i`=1 adds one to `level_o`. The exception is when `level_o` is already 64: that byte is dropped, even if an acknowledge arrives in the same cycle.
- R3: A flush starts once `level_o` reaches the burst threshold set by `burst_sel_i`. The encodings are 2'b00 = 4 bytes, 2'b01 = 16 bytes, 2'b10 = 32 bytes and 2'b11 = 32 bytes. Below the threshold, no request is raised.
- R4: A cycle with `intr_pend_i`=1 starts a flush.
- R5: A cycle with `reg_wr_i`=1 starts a flush, with two exceptions. `reg_kind_i`=2 (test register) never starts one. `reg_kind_i`=1 (address register) does not start one while `diag_i`=1. Kinds 0 and 3 are general registers.
- R6: A cycle with `cmd_reset_i` or `cmd_inval_i` set, and no error pending, starts a flush.
- R7: A cycle with `addr_reload_i`=1 starts a flush only when `diag_i`=0.
- R8: A flush that starts on the edge after a trigger cycle requests exactly the `level_o` value of that trigger cycle. Bytes arriving in the trigger cycle or during the flush stay counted. On acknowledge, `level_o` drops by the requested count.
- R9: `drain_req_o` and `drain_cnt_o` hold steady until a cycle with `drain_ack_i`=1. Triggers seen while a request is outstanding are absorbed into it and raise no second request.
- R10: While `err_pend_i`=1, no new flush request is raised, whatever the trigger.
- R11: With `err_pend_i`=1, a reset command, an invalidate command or a non-diagnostic address reload discards the buffer. On the next edge, `level_o` becomes 0 (1 if a byte arrived in that cycle), any outstanding request is withdrawn, and `inval_o` pulses for one cycle.
- R12: A trigger while `level_o` is 0 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_wr_i | input | 1 | A received byte enters the buffer this cycle |
| burst_sel_i | input | 2 | Burst threshold select (4/16/32/32) |
| intr_pend_i | input | 1 | Interrupt-pending flag |
| reg_wr_i | input | 1 | Software register write this cycle |
| reg_kind_i | input | 2 | Target of the write: 0/3 general, 1 address, 2 test |
| diag_i | input | 1 | Diagnostic mode flag |
| cmd_reset_i | input | 1 | Reset command pulse |
| cmd_inval_i | input | 1 | Invalidate command pulse |
| addr_reload_i | input | 1 | Address register reloads from next-address register |
| err_pend_i | input | 1 | Memory error pending |
| drain_ack_i | input | 1 | Memory side has completed the flush |
| drain_req_o | output | 1 | Flush request |
| drain_cnt_o | output | 7 | Bytes to flush |
| level_o | output | 7 | Bytes currently held |
| inval_o | output | 1 | One-cycle pulse: buffer contents discarded |

## Verification
The bench aims at the exclusions among the triggers: test-register writes, and address writes or reloads in diagnostic mode. A decoder that got these wrong would flush when it must not. It also tests every threshold encoding one byte short of the threshold and exactly at it, which catches an off-by-one or a swapped select. Triggers are tested with an error pending, both with and without a flush outstanding. A design that ignored the error would raise a request, and one that failed to withdraw the request would leave it hanging after the discard. The bench also writes bytes in the trigger cycle, during a flush and into a full buffer. This exposes a flush count that swallows late bytes and a counter that wraps past 64.

// File: rtl/pp_drain_pkg.sv
package pp_drain_pkg;

    // Target of a software register write
    typedef enum logic [1:0] {
        REG_GENERAL = 2'd0,
        REG_ADDR    = 2'd1,
        REG_TEST    = 2'd2,
        REG_SPARE   = 2'd3
    } reg_kind_e;

    // Burst threshold select encodings
    localparam logic [1:0] BSEL_SMALL = 2'b00;
    localparam logic [1:0] BSEL_MID   = 2'b01;

endpackage

// File: rtl/pp_drain_trigger.sv
module pp_drain_trigger
    import pp_drain_pkg::*;
#(
    parameter int LVL_W    = 7,
    parameter int TH_SMALL = 4,
    parameter int TH_MID   = 16,
    parameter int TH_LARGE = 32
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       burst_sel_i,
    input  logic             intr_pend_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_kind_i,
    input  logic             diag_i,
    input  logic             cmd_reset_i,
    input  logic             cmd_inval_i,
    input  logic             addr_reload_i,
    input  logic             err_pend_i,
    output logic             flush_evt_o,
    output logic             discard_evt_o
);

    logic [LVL_W-1:0] thr;
    logic             thr_hit;
    logic             reg_evt;
    logic             reload_evt;
    logic             ctrl_evt;
    reg_kind_e        kind;

    always_comb begin
        case (burst_sel_i)
            BSEL_SMALL: thr = LVL_W'(TH_SMALL);
            BSEL_MID:   thr = LVL_W'(TH_MID);
            default:    thr = LVL_W'(TH_LARGE);
        endcase
    end

    assign kind    = reg_kind_e'(reg_kind_i);
    assign thr_hit = (level_i >= thr);

    // Register writes: test register never, address register not in diag mode
    assign reg_evt    = reg_wr_i && (kind != REG_TEST) && !((kind == REG_ADDR) && diag_i);
    assign reload_evt = addr_reload_i && !diag_i;
    assign ctrl_evt   = cmd_reset_i || cmd_inval_i || reload_evt;

    assign flush_evt_o   = !err_pend_i && (thr_hit || intr_pend_i || reg_evt || ctrl_evt);
    assign discard_evt_o = err_pend_i && ctrl_evt;

endmodule

// File: rtl/pp_fill_count.sv
module pp_fill_count #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr_i,
    input  logic             clear_i,
    input  logic             dec_en_i,
    input  logic [LVL_W-1:0] dec_amt_i,
    output logic [LVL_W-1:0] level_o
);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic             accept;
    logic [LVL_W-1:0] base;

    always_comb begin
        st_d   = st_q;
        accept = byte_wr_i && (st_q.level < LVL_W'(DEPTH));
        if (clear_i) begin
            base = '0;
        end else if (dec_en_i) begin
            base = st_q.level - dec_amt_i;
        end else begin
            base = st_q.level;
        end
        st_d.level = base + LVL_W'(accept);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/pp_drain_seq.sv
module pp_drain_seq #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_evt_i,
    input  logic             discard_evt_i,
    input  logic             drain_ack_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             drain_req_o,
    output logic [LVL_W-1:0] drain_cnt_o,
    output logic             inval_o,
    output logic             dec_en_o,
    output logic [LVL_W-1:0] dec_amt_o
);

    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] cnt;
        logic             inval;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.inval = discard_evt_i;
        if (discard_evt_i) begin
            st_d.req = 1'b0;
        end else if (st_q.req && drain_ack_i) begin
            st_d.req = 1'b0;
        end else if (!st_q.req && flush_evt_i && (level_i != '0)) begin
            st_d.req = 1'b1;
            st_d.cnt = level_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drain_req_o = st_q.req;
    assign drain_cnt_o = st_q.cnt;
    assign inval_o     = st_q.inval;
    assign dec_en_o    = st_q.req && drain_ack_i && !discard_evt_i;
    assign dec_amt_o   = st_q.cnt;

endmodule

// File: rtl/pp_rx_drain_ctrl.sv
module pp_rx_drain_ctrl #(
    parameter int DEPTH    = 64,
    parameter int TH_SMALL = 4,
    parameter int TH_MID   = 16,
    parameter int TH_LARGE = 32,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr_i,
    input  logic [1:0]       burst_sel_i,
    input  logic             intr_pend_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_kind_i,
    input  logic             diag_i,
    input  logic             cmd_reset_i,
    input  logic             cmd_inval_i,
    input  logic             addr_reload_i,
    input  logic             err_pend_i,
    input  logic             drain_ack_i,
    output logic             drain_req_o,
    output logic [LVL_W-1:0] drain_cnt_o,
    output logic [LVL_W-1:0] level_o,
    output logic             inval_o
);

    logic             flush_evt;
    logic             discard_evt;
    logic             dec_en;
    logic [LVL_W-1:0] dec_amt;
    logic [LVL_W-1:0] level;

    pp_drain_trigger #(
        .LVL_W   (LVL_W),
        .TH_SMALL(TH_SMALL),
        .TH_MID  (TH_MID),
        .TH_LARGE(TH_LARGE)
    ) u_trigger (
        .level_i      (level),
        .burst_sel_i  (burst_sel_i),
        .intr_pend_i  (intr_pend_i),
        .reg_wr_i     (reg_wr_i),
        .reg_kind_i   (reg_kind_i),
        .diag_i       (diag_i),
        .cmd_reset_i  (cmd_reset_i),
        .cmd_inval_i  (cmd_inval_i),
        .addr_reload_i(addr_reload_i),
        .err_pend_i   (err_pend_i),
        .flush_evt_o  (flush_evt),
        .discard_evt_o(discard_evt)
    );

    pp_fill_count #(
        .DEPTH(DEPTH),
        .LVL_W(LVL_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_wr_i(byte_wr_i),
        .clear_i  (discard_evt),
        .dec_en_i (dec_en),
        .dec_amt_i(dec_amt),
        .level_o  (level)
    );

    pp_drain_seq #(
        .LVL_W(LVL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_evt_i  (flush_evt),
        .discard_evt_i(discard_evt),
        .drain_ack_i  (drain_ack_i),
        .level_i      (level),
        .drain_req_o  (drain_req_o),
        .drain_cnt_o  (drain_cnt_o),
        .inval_o      (inval_o),
        .dec_en_o     (dec_en),
        .dec_amt_o    (dec_amt)
    );

    assign level_o = level;

endmodule

// File: rtl/pp_rx_drain_chk.sv
module pp_rx_drain_chk #(
    parameter int DEPTH  = 64,
    parameter int LVL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_wr_i,
    input logic             intr_pend_i,
    input logic             cmd_reset_i,
    input logic             cmd_inval_i,
    input logic             err_pend_i,
    input logic             drain_ack_i,
    input logic             drain_req_o,
    input logic [LVL_W-1:0] drain_cnt_o,
    input logic [LVL_W-1:0] level_o,
    input logic             inval_o
);

    // R2: occupancy never exceeds the buffer depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));

    // R8: a pending request never asks for more than is held, and never for zero
    a_r8_cnt_in_level: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req_o |-> (drain_cnt_o != '0) && (drain_cnt_o <= level_o));

    // R9: request and count hold until acknowledged (or withdrawn by a discard)
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_o && !drain_ack_i) |=> ((drain_req_o && $stable(drain_cnt_o)) || inval_o));

    // R10: an error pending blocks any new request
    a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req_o && err_pend_i) |=> !drain_req_o);

    // R11: command under a pending error discards
    a_r11_discard_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pend_i && (cmd_reset_i || cmd_inval_i)) |=> inval_o);

    // R11: after a discard no request remains and at most one byte is held
    a_r11_discard_state: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |-> (!drain_req_o && (level_o <= LVL_W'(1))));

    // R12: an empty buffer raises no request
    a_r12_no_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req_o && (level_o == '0)) |=> !drain_req_o);

endmodule

bind pp_rx_drain_ctrl pp_rx_drain_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_wr_i  (byte_wr_i),
    .intr_pend_i(intr_pend_i),
    .cmd_reset_i(cmd_reset_i),
    .cmd_inval_i(cmd_inval_i),
    .err_pend_i (err_pend_i),
    .drain_ack_i(drain_ack_i),
    .drain_req_o(drain_req_o),
    .drain_cnt_o(drain_cnt_o),
    .level_o    (level_o),
    .inval_o    (inval_o)
);

// File: tb/pp_rx_drain_ctrl_bench.sv
`timescale 1ns/1ps
module pp_rx_drain_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bwr = 1'b0;
    logic [1:0] bsel = 2'b00;
    logic       intr = 1'b0;
    logic       regwr = 1'b0;
    logic [1:0] kind = 2'd0;
    logic       diag = 1'b0;
    logic       creset = 1'b0;
    logic       cinval = 1'b0;
    logic       reload = 1'b0;
    logic       err = 1'b0;
    logic       ack = 1'b0;
    logic       req;
    logic [6:0] cnt;
    logic [6:0] lvl;
    logic       inv;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference state
    int  m_lvl = 0;
    int  m_cnt = 0;
    bit  m_req = 0;
    bit  m_inv = 0;

    always #10 clk = ~clk;

    pp_rx_drain_ctrl u_pp_rx_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_wr_i(bwr), .burst_sel_i(bsel),
        .intr_pend_i(intr), .reg_wr_i(regwr), .reg_kind_i(kind), .diag_i(diag),
        .cmd_reset_i(creset), .cmd_inval_i(cinval), .addr_reload_i(reload),
        .err_pend_i(err), .drain_ack_i(ack), .drain_req_o(req),
        .drain_cnt_o(cnt), .level_o(lvl), .inval_o(inv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_lvl = 0; m_cnt = 0; m_req = 0; m_inv = 0;
        end else begin
            int  thr;
            bit  flush, disc, acc, ctl;
            thr   = (bsel == 2'b00) ? 4 : (bsel == 2'b01) ? 16 : 32;
            ctl   = creset || cinval || (reload && !diag);
            flush = intr || ctl || (m_lvl >= thr)
                    || (regwr && kind != 2'd2 && !(kind == 2'd1 && diag));
            disc  = err && ctl;
            acc   = bwr && (m_lvl < 64);
            if (disc) begin
                m_req = 0; m_inv = 1; m_lvl = 0;
            end else begin
                m_inv = 0;
                if (m_req && ack) begin
                    m_lvl = m_lvl - m_cnt; m_req = 0;
                end else if (!m_req && flush && !err && m_lvl > 0) begin
                    m_req = 1; m_cnt = m_lvl;
                end
            end
            if (acc) m_lvl = m_lvl + 1;
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 model req", int'(req), int'(m_req));
            chk("R2 model level", int'(lvl), m_lvl);
            chk("R11 model inval", int'(inv), int'(m_inv));
            if (m_req) chk("R8 model count", int'(cnt), m_cnt);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int n);
        repeat (n) begin tick(); bwr = 1'b1; end
        tick(); bwr = 1'b0;
    endtask

    task automatic do_ack();
        tick(); ack = 1'b1; tick(); ack = 1'b0;
    endtask

    // 0 interrupt, 1 reset cmd, 2 invalidate cmd, 3 address reload
    task automatic evt(input int which);
        tick();
        case (which)
            0: intr = 1'b1;
            1: creset = 1'b1;
            2: cinval = 1'b1;
            default: reload = 1'b1;
        endcase
        tick();
        intr = 1'b0; creset = 1'b0; cinval = 1'b0; reload = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] k);
        tick(); regwr = 1'b1; kind = k; tick(); regwr = 1'b0; kind = 2'd0;
    endtask

    initial begin
        tick(2);
        chk("R1 reset req", int'(req), 0);
        chk("R1 reset level", int'(lvl), 0);
        chk("R1 reset inval", int'(inv), 0);
        rst_n = 1'b1;

        // R3 threshold 4
        push(3); tick(2);
        chk("R3 below 4", int'(req), 0);
        push(1); tick();
        chk("R3 at 4 req", int'(req), 1);
        chk("R3 at 4 cnt", int'(cnt), 4);
        tick(5);
        chk("R9 held req", int'(req), 1);
        chk("R9 held cnt", int'(cnt), 4);
        push(2);
        chk("R8 late bytes kept", int'(lvl), 6);
        do_ack();
        chk("R8 ack clears req", int'(req), 0);
        chk("R8 level after ack", int'(lvl), 2);

        // R3 threshold 16
        bsel = 2'b01;
        push(13); tick(2);
        chk("R3 below 16", int'(req), 0);
        push(1); tick();
        chk("R3 at 16 cnt", int'(cnt), 16);
        do_ack();

        // R3 threshold 32 for both 2'b10 and 2'b11
        for (int s = 2; s < 4; s++) begin
            bsel = 2'(s);
            push(31); tick(2);
            chk("R3 below 32", int'(req), 0);
            push(1); tick();
            chk("R3 at 32 cnt", int'(cnt), 32);
            do_ack();
            chk("R3 empty after", int'(lvl), 0);
        end

        // R4 interrupt
        push(5); tick(2);
        chk("R4 no req before", int'(req), 0);
        evt(0);
        chk("R4 intr req", int'(req), 1);
        chk("R4 intr cnt", int'(cnt), 5);
        do_ack();

        // R5 register writes
        push(3);
        reg_write(2'd2); tick(2);
        chk("R5 test reg ignored", int'(req), 0);
        diag = 1'b1;
        reg_write(2'd1); tick(2);
        chk("R5 addr reg in diag ignored", int'(req), 0);
        diag = 1'b0;
        reg_write(2'd1);
        chk("R5 addr reg req", int'(req), 1);
        chk("R5 addr reg cnt", int'(cnt), 3);
        do_ack();
        push(2);
        reg_write(2'd0);
        chk("R5 general reg cnt", int'(cnt), 2);
        do_ack();

        // R7 address reload
        push(3);
        diag = 1'b1;
        evt(3); tick(2);
        chk("R7 reload in diag ignored", int'(req), 0);
        diag = 1'b0;
        evt(3);
        chk("R7 reload cnt", int'(cnt), 3);
        chk("R7 no inval", int'(inv), 0);
        do_ack();

        // R6 reset / invalidate commands without error
        push(2);
        evt(1);
        chk("R6 reset cmd cnt", int'(cnt), 2);
        chk("R6 reset no inval", int'(inv), 0);
        do_ack();
        push(2);
        evt(2);
        chk("R6 inval cmd req", int'(req), 1);
        do_ack();

        // R10 error blocks, R11 discard
        err = 1'b1;
        push(3);
        evt(0); tick(2);
        chk("R10 intr blocked", int'(req), 0);
        reg_write(2'd0); tick(2);
        chk("R10 reg write blocked", int'(req), 0);
        chk("R10 level kept", int'(lvl), 3);
        evt(2);
        chk("R11 inval pulse", int'(inv), 1);
        chk("R11 level cleared", int'(lvl), 0);
        tick();
        chk("R11 pulse one cycle", int'(inv), 0);
        err = 1'b0;

        // R11 discard withdraws outstanding request
        push(4);
        evt(0);
        chk("R11 pre req", int'(req), 1);
        err = 1'b1;
        evt(3);
        chk("R11 req withdrawn", int'(req), 0);
        chk("R11 inval on reload", int'(inv), 1);
        chk("R11 level zero", int'(lvl), 0);
        err = 1'b0;

        // R12 empty buffer
        evt(0); tick();
        chk("R12 no req when empty", int'(req), 0);

        // R8 byte in trigger cycle stays queued
        push(3);
        tick(); bwr = 1'b1; intr = 1'b1;
        tick(); bwr = 1'b0; intr = 1'b0;
        chk("R8 trigger-cycle cnt", int'(cnt), 3);
        chk("R8 trigger-cycle level", int'(lvl), 4);
        do_ack();
        chk("R8 residue", int'(lvl), 1);
        evt(0);
        do_ack();

        // R2 full buffer
        err = 1'b1;
        push(70);
        chk("R2 saturates at 64", int'(lvl), 64);
        err = 1'b0;
        tick();
        chk("R2 full drain cnt", int'(cnt), 64);
        push(3);
        chk("R2 drop when full", int'(lvl), 64);
        do_ack();
        chk("R2 empty after full drain", int'(lvl), 0);

        tick(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule